// File: doc/BRIEF.md
# Flagged Multi-Function Byte ALU

A purely combinational arithmetic and logic unit on two byte operands, a carry input and a four-bit operation select. It returns a low result byte, a high result byte and seven status flags. The operations cover bitwise logic, three kinds of addition, subtraction, signed and unsigned multiplication, two rotates, three shifts and a conversion from packed decimal to binary. The high byte is only non-zero for the operations that return a double-width result.

Besides the usual zero, carry, overflow and sign flags, the unit reports whether the low byte is a bit palindrome and whether it is a prime number. It also provides a summary flag that is set whenever zero, carry or overflow is set. Each operation defines its own set of meaningful flags. Any flag that an operation leaves undefined is driven low, so a consumer can use the flags without decoding the operation again.

Top module: `alu_flagged`

## Requirements
- R1: Codes 0000, 0001, 0010 and 0011 give resLo = A AND B, A OR B, A XOR B and A XNOR B. For these codes carryFlag, ovfFlag and negFlag are 0.
- R2: Code 0100 gives {carryFlag,resLo} = A+B as a 9-bit sum. Code 0110 gives {carryFlag,resLo} = A+B+carryIn. negFlag is 0 for both.
- R3: Code 0101 gives resLo = A+B modulo 256. ovfFlag is set when both operands have the same sign bit and the sign bit of the sum differs from it. negFlag = resLo[7] and carryFlag = 0.
- R4: Code 0111 (signed) and code 1000 (unsigned) give the full 16-bit product on {resHi,resLo}. negFlag = resLo[7] for code 0111 and 0 for code 1000.
- R5: Code 1001 gives resLo = A-B modulo 256. carryFlag is a borrow, set exactly when A < B unsigned, and negFlag is 0.
- R6: Code 1010 rotates A left by one bit with carryFlag = 0. Code 1011 rotates the 9-bit value {carryIn,A} left by one, giving carryFlag = A[7] and resLo = {A[6:0],carryIn}.
- R7: Code 1100 gives resLo = A>>1 (zero fill) and code 1101 gives resLo = A>>1 with A[7] kept. For both, carryFlag = A[0]. Code 1110 gives resLo = A<<1 with carryFlag = A[7] and ovfFlag = A[7] XOR A[6]. negFlag = resLo[7] for codes 1101 and 1110, and 0 for code 1100.
- R8: Code 1111 reads {B,A} as four 4-bit decimal digits, most significant in B[7:4], and returns their binary value on {resHi,resLo}. Each nibble is weighted by its decimal place, even when it is above 9. carryFlag is 0.
- R9: zeroFlag is set when resLo = 0 for single-byte operations, and when both resHi and resLo are 0 for codes 0111, 1000 and 1111.
- R10: anyFlag equals zeroFlag OR carryFlag OR ovfFlag for every code.
- R11: palFlag is set exactly when resLo equals its bit-reversed value.
- R12: primeFlag is set exactly when resLo, read as an unsigned number from 0 to 255, is prime. 0 and 1 are not prime.
- R13: resHi is 0 for all codes except 0111, 1000 and 1111. ovfFlag is 0 for all codes except 0101 and 1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 8 | First operand (low decimal byte for code 1111) |
| opB | input | 8 | Second operand (high decimal byte for code 1111) |
| carryIn | input | 1 | Carry input used by codes 0110 and 1011 |
| opCode | input | 4 | Operation select |
| resLo | output | 8 | Low result byte |
| resHi | output | 8 | High result byte, 0 for single-byte operations |
| zeroFlag | output | 1 | Result is zero |
| carryFlag | output | 1 | Carry, borrow or shifted-out bit |
| ovfFlag | output | 1 | Signed overflow |
| negFlag | output | 1 | Result is negative |
| anyFlag | output | 1 | OR of zero, carry and overflow |
| palFlag | output | 1 | Low byte is a bit palindrome |
| primeFlag | output | 1 | Low byte is prime |

## Verification
The bench builds the unit with its default byte width, W = 8. At this width four decimal digits fit exactly in the two operand bytes, and the prime detector must cover every prime up to 251. A small table pins down carries, sign extension of the signed product and the decimal conversion. A sweep then runs all sixteen codes over sign-boundary and alternating-bit operand patterns with both carry values. Directed cases probe the edges of the prime and palindrome detectors and the zero flag of the wide results.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'h0,
    OP_OR   = 4'h1,
    OP_XOR  = 4'h2,
    OP_XNOR = 4'h3,
    OP_ADDU = 4'h4,
    OP_ADDS = 4'h5,
    OP_ADDC = 4'h6,
    OP_MULS = 4'h7,
    OP_MULU = 4'h8,
    OP_SUB  = 4'h9,
    OP_ROL  = 4'hA,
    OP_RLC  = 4'hB,
    OP_LSR  = 4'hC,
    OP_ASR  = 4'hD,
    OP_LSL  = 4'hE,
    OP_BCD  = 4'hF
  } aluOp_e;

  // Strobes from the decoder to the datapath and flag logic
  typedef struct packed {
    logic wide;      // double-width result on hi:lo
    logic keepCout;  // carry flag defined
    logic keepOvf;   // overflow flag defined
    logic signN;     // negative flag follows the result sign bit
  } aluCtrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] opCode,
  output aluCtrl_t   ctrl
);

  aluOp_e op;
  assign op = aluOp_e'(opCode);

  always_comb begin
    ctrl = '0;
    unique case (op)
      OP_ADDU, OP_ADDC, OP_SUB, OP_RLC, OP_LSR: ctrl.keepCout = 1'b1;
      OP_ADDS: begin
        ctrl.keepOvf = 1'b1;
        ctrl.signN   = 1'b1;
      end
      OP_MULS: begin
        ctrl.wide  = 1'b1;
        ctrl.signN = 1'b1;
      end
      OP_MULU, OP_BCD: ctrl.wide = 1'b1;
      OP_ASR: begin
        ctrl.keepCout = 1'b1;
        ctrl.signN    = 1'b1;
      end
      OP_LSL: begin
        ctrl.keepCout = 1'b1;
        ctrl.keepOvf  = 1'b1;
        ctrl.signN    = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic [3:0]   opCode,
  output logic [W-1:0] rawLo,
  output logic [W-1:0] rawHi,
  output logic         rawCout,
  output logic         rawOvf
);

  localparam int PW = 2 * W;
  localparam int ND = PW / 4;

  aluOp_e op;
  assign op = aluOp_e'(opCode);

  logic [W:0]    sumAB;
  logic [W:0]    sumABC;
  logic [W:0]    diffAB;
  logic [PW-1:0] extA, extB, prodS, prodU, bcdVal;

  assign sumAB  = {1'b0, a} + {1'b0, b};
  assign sumABC = sumAB + {{W{1'b0}}, cin};
  assign diffAB = {1'b0, a} - {1'b0, b};
  assign extA   = {{W{a[W-1]}}, a};
  assign extB   = {{W{b[W-1]}}, b};
  assign prodS  = extA * extB;
  assign prodU  = {{W{1'b0}}, a} * {{W{1'b0}}, b};

  // decimal digits of {b,a}, most significant first
  always_comb begin
    logic [PW-1:0] pair;
    pair   = {b, a};
    bcdVal = '0;
    for (int d = ND - 1; d >= 0; d--) begin
      bcdVal = bcdVal * PW'(10) + PW'(pair[d*4 +: 4]);
    end
  end

  always_comb begin
    rawLo   = '0;
    rawHi   = '0;
    rawCout = 1'b0;
    rawOvf  = 1'b0;
    unique case (op)
      OP_AND:  rawLo = a & b;
      OP_OR:   rawLo = a | b;
      OP_XOR:  rawLo = a ^ b;
      OP_XNOR: rawLo = ~(a ^ b);
      OP_ADDU: {rawCout, rawLo} = sumAB;
      OP_ADDS: begin
        rawLo  = sumAB[W-1:0];
        rawOvf = (a[W-1] == b[W-1]) && (sumAB[W-1] != a[W-1]);
      end
      OP_ADDC: {rawCout, rawLo} = sumABC;
      OP_MULS: {rawHi, rawLo} = prodS;
      OP_MULU: {rawHi, rawLo} = prodU;
      OP_SUB: begin
        rawLo   = diffAB[W-1:0];
        rawCout = diffAB[W];
      end
      OP_ROL:  rawLo = {a[W-2:0], a[W-1]};
      OP_RLC:  {rawCout, rawLo} = {a, cin};
      OP_LSR:  {rawLo, rawCout} = {1'b0, a};
      OP_ASR:  {rawLo, rawCout} = {a[W-1], a};
      OP_LSL: begin
        {rawCout, rawLo} = {a, 1'b0};
        rawOvf = a[W-1] ^ a[W-2];
      end
      OP_BCD:  {rawHi, rawLo} = bcdVal;
      default: rawLo = '0;
    endcase
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  aluCtrl_t     ctrl,
  input  logic [W-1:0] resLo,
  input  logic [W-1:0] resHi,
  input  logic         rawCout,
  input  logic         rawOvf,
  output logic         zeroFlag,
  output logic         carryFlag,
  output logic         ovfFlag,
  output logic         negFlag,
  output logic         anyFlag,
  output logic         palFlag,
  output logic         primeFlag
);

  // trial divisors up to the square root of the largest value
  localparam int MAXDIV = 1 << (W / 2);

  assign zeroFlag  = (resLo == '0) && (!ctrl.wide || resHi == '0);
  assign carryFlag = ctrl.keepCout & rawCout;
  assign ovfFlag   = ctrl.keepOvf & rawOvf;
  assign negFlag   = ctrl.signN & resLo[W-1];
  assign anyFlag   = zeroFlag | carryFlag | ovfFlag;

  always_comb begin
    palFlag = 1'b1;
    for (int i = 0; i < W / 2; i++) begin
      if (resLo[i] != resLo[W-1-i]) palFlag = 1'b0;
    end
  end

  always_comb begin
    primeFlag = (resLo > W'(1));
    for (int d = 2; d <= MAXDIV; d++) begin
      if ((resLo > W'(d)) && ((resLo % W'(d)) == '0)) primeFlag = 1'b0;
    end
  end

endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  input  logic [3:0]   opCode,
  output logic [W-1:0] resLo,
  output logic [W-1:0] resHi,
  output logic         zeroFlag,
  output logic         carryFlag,
  output logic         ovfFlag,
  output logic         negFlag,
  output logic         anyFlag,
  output logic         palFlag,
  output logic         primeFlag
);

  aluCtrl_t     ctrl;
  logic [W-1:0] rawHi;
  logic         rawCout, rawOvf;

  alu_ctrl u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  alu_datapath #(.W(W)) u_dp (
    .a       (opA),
    .b       (opB),
    .cin     (carryIn),
    .opCode  (opCode),
    .rawLo   (resLo),
    .rawHi   (rawHi),
    .rawCout (rawCout),
    .rawOvf  (rawOvf)
  );

  assign resHi = ctrl.wide ? rawHi : '0;

  alu_flags #(.W(W)) u_flags (
    .ctrl      (ctrl),
    .resLo     (resLo),
    .resHi     (resHi),
    .rawCout   (rawCout),
    .rawOvf    (rawOvf),
    .zeroFlag  (zeroFlag),
    .carryFlag (carryFlag),
    .ovfFlag   (ovfFlag),
    .negFlag   (negFlag),
    .anyFlag   (anyFlag),
    .palFlag   (palFlag),
    .primeFlag (primeFlag)
  );

endmodule

// File: rtl/alu_flagged_chk.sv
module alu_flagged_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         carryIn,
  input logic [3:0]   opCode,
  input logic [W-1:0] resLo,
  input logic [W-1:0] resHi,
  input logic         zeroFlag,
  input logic         carryFlag,
  input logic         ovfFlag,
  input logic         negFlag,
  input logic         anyFlag,
  input logic         palFlag,
  input logic         primeFlag
);

  logic isWide;
  assign isWide = (opCode == 4'h7) || (opCode == 4'h8) || (opCode == 4'hF);

  always_comb begin
    if (!$isunknown({opA, opB, carryIn, opCode})) begin
      // R10
      any_or_chk: assert (anyFlag == (zeroFlag | carryFlag | ovfFlag));
      // R13
      hi_zero_chk: assert (isWide || resHi == '0);
      // R13
      ovf_mask_chk: assert (!ovfFlag || opCode == 4'h5 || opCode == 4'hE);
      // R9
      zero_res_chk: assert (!zeroFlag || resLo == '0);
      // R5
      sub_borrow_chk: assert (opCode != 4'h9 || carryFlag == (opA < opB));
      // R11
      pal_end_chk: assert (!palFlag || resLo[0] == resLo[W-1]);
      // R12
      prime_odd_chk: assert (!primeFlag || resLo[0] || resLo == W'(2));
      // R1
      logic_flags_chk: assert (opCode > 4'h3 || !(carryFlag | ovfFlag | negFlag));
    end
  end

endmodule

bind alu_flagged alu_flagged_chk #(.W(W)) u_chk (.*);

// File: tb/tb_alu_flagged.sv
module tb_alu_flagged;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opA, opB;
  logic       carryIn;
  logic [3:0] opCode;
  logic [7:0] resLo, resHi;
  logic       zeroFlag, carryFlag, ovfFlag, negFlag, anyFlag, palFlag, primeFlag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(PERIOD / 2) clk = ~clk;

  alu_flagged #(.W(8)) dut (.*);

  // op, a, b, cin, expected hi, lo, carry
  localparam logic [37:0] VEC [16] = '{
    {4'h0, 8'hF0, 8'h3C, 1'b0, 8'h00, 8'h30, 1'b0},
    {4'h1, 8'hF0, 8'h0C, 1'b0, 8'h00, 8'hFC, 1'b0},
    {4'h2, 8'hFF, 8'h0F, 1'b0, 8'h00, 8'hF0, 1'b0},
    {4'h3, 8'hAA, 8'h55, 1'b1, 8'h00, 8'h00, 1'b0},
    {4'h4, 8'hFF, 8'h01, 1'b0, 8'h00, 8'h00, 1'b1},
    {4'h5, 8'h7F, 8'h01, 1'b0, 8'h00, 8'h80, 1'b0},
    {4'h6, 8'h80, 8'h7F, 1'b1, 8'h00, 8'h00, 1'b1},
    {4'h7, 8'hFF, 8'h02, 1'b0, 8'hFF, 8'hFE, 1'b0},
    {4'h8, 8'hFF, 8'h02, 1'b0, 8'h01, 8'hFE, 1'b0},
    {4'h9, 8'h10, 8'h20, 1'b0, 8'h00, 8'hF0, 1'b1},
    {4'hA, 8'h81, 8'h00, 1'b1, 8'h00, 8'h03, 1'b0},
    {4'hB, 8'h80, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1},
    {4'hC, 8'h03, 8'h00, 1'b0, 8'h00, 8'h01, 1'b1},
    {4'hD, 8'h81, 8'h00, 1'b0, 8'h00, 8'hC0, 1'b1},
    {4'hE, 8'hC1, 8'h00, 1'b0, 8'h00, 8'h82, 1'b1},
    {4'hF, 8'h34, 8'h12, 1'b0, 8'h04, 8'hD2, 1'b0}
  };

  localparam logic [7:0] PAT [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hA3, 8'h09};

  function automatic bit refPrime(input logic [7:0] v);
    if (v < 8'd2) return 1'b0;
    for (int d = 2; d * d <= int'(v); d++) begin
      if (int'(v) % d == 0) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit refPal(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      if (v[i] != v[7-i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  // bundle: hi, lo, z, c, v, n, any, pal, prime
  function automatic logic [22:0] refModel(input logic [3:0] op, input logic [7:0] a,
                                           input logic [7:0] b, input logic ci);
    logic [7:0] x, y;
    logic c, v, n, z, wide;
    int prod;
    x = 8'h00; y = 8'h00; c = 1'b0; v = 1'b0; n = 1'b0; wide = 1'b0;
    case (op)
      4'h0: x = a & b;
      4'h1: x = a | b;
      4'h2: x = a ^ b;
      4'h3: x = ~(a ^ b);
      4'h4: {c, x} = 9'(int'(a) + int'(b));
      4'h5: begin
        x = a + b;
        v = (a[7] == b[7]) && (x[7] != a[7]);
        n = x[7];
      end
      4'h6: {c, x} = 9'(int'(a) + int'(b) + int'(ci));
      4'h7: begin
        prod = int'($signed(a)) * int'($signed(b));
        {y, x} = 16'(prod);
        n = x[7]; wide = 1'b1;
      end
      4'h8: begin
        prod = int'(a) * int'(b);
        {y, x} = 16'(prod);
        wide = 1'b1;
      end
      4'h9: begin x = a - b; c = (a < b); end
      4'hA: x = {a[6:0], a[7]};
      4'hB: begin c = a[7]; x = {a[6:0], ci}; end
      4'hC: begin c = a[0]; x = a >> 1; end
      4'hD: begin c = a[0]; x = {a[7], a[7:1]}; n = x[7]; end
      4'hE: begin c = a[7]; x = a << 1; v = a[7] ^ a[6]; n = x[7]; end
      default: begin
        prod = int'(b[7:4]) * 1000 + int'(b[3:0]) * 100 + int'(a[7:4]) * 10 + int'(a[3:0]);
        {y, x} = 16'(prod);
        wide = 1'b1;
      end
    endcase
    z = (x == 8'h00) && (!wide || y == 8'h00);
    return {y, x, z, c, v, n, z | c | v, refPal(x), refPrime(x)};
  endfunction

  function automatic logic [22:0] dutBundle();
    return {resHi, resLo, zeroFlag, carryFlag, ovfFlag, negFlag, anyFlag, palFlag, primeFlag};
  endfunction

  task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b, input logic ci);
    @(posedge clk);
    opCode = op; opA = a; opB = b; carryIn = ci;
    @(negedge clk);
  endtask

  task automatic runModel(input string req, input logic [3:0] op, input logic [7:0] a,
                          input logic [7:0] b, input logic ci);
    apply(op, a, b, ci);
    check(req, dutBundle(), refModel(op, a, b, ci));
  endtask

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'h0, 4'h1, 4'h2, 4'h3: return "R1";
      4'h4, 4'h6: return "R2";
      4'h5: return "R3";
      4'h7, 4'h8: return "R4";
      4'h9: return "R5";
      4'hA, 4'hB: return "R6";
      4'hC, 4'hD, 4'hE: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

  initial begin
    opA = 8'h00; opB = 8'h00; carryIn = 1'b0; opCode = 4'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: AND of zeros, zero and palindrome set (R9, R11)
    check("R9 reset", dutBundle(), {8'h00, 8'h00, 7'b1000110});

    // table walk: hi, lo, carry per code
    for (int i = 0; i < 16; i++) begin
      apply(VEC[i][37:34], VEC[i][33:26], VEC[i][25:18], VEC[i][17]);
      check(reqOf(VEC[i][37:34]), {6'b0, resHi, resLo, carryFlag},
            {6'b0, VEC[i][16:9], VEC[i][8:1], VEC[i][0]});
    end

    // sweep all codes over boundary patterns against the model
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          for (int ci = 0; ci < 2; ci++) begin
            runModel(reqOf(4'(op)), 4'(op), PAT[i], PAT[j], 1'(ci));
          end
        end
      end
    end

    // R3 signed overflow both directions
    apply(4'h5, 8'h80, 8'hFF, 1'b0);
    check("R3 neg overflow", {22'b0, ovfFlag}, 23'd1);
    apply(4'h5, 8'h40, 8'hC0, 1'b0);
    check("R3 no overflow", {21'b0, ovfFlag, zeroFlag}, 23'd1);

    // R7 shift-left overflow and sign
    apply(4'hE, 8'h40, 8'h00, 1'b0);
    check("R7 lsl ovf", {20'b0, ovfFlag, negFlag, carryFlag}, 23'b110);

    // R9 wide zero needs both bytes
    apply(4'h8, 8'h00, 8'h5A, 1'b0);
    check("R9 mul zero", {22'b0, zeroFlag}, 23'd1);
    apply(4'h8, 8'h10, 8'h10, 1'b0);
    check("R9 hi only", {resHi, resLo, 6'b0, zeroFlag}, {8'h01, 8'h00, 7'b0});

    // R8 largest decimal value 9999
    apply(4'hF, 8'h99, 8'h99, 1'b0);
    check("R8 max", {7'b0, resHi, resLo}, {7'b0, 16'd9999});

    // R12 primes and non-primes via AND with FF
    for (int v = 0; v < 256; v++) begin
      apply(4'h0, 8'(v), 8'hFF, 1'b0);
      check("R12 prime", {22'b0, primeFlag}, {22'b0, refPrime(8'(v))});
      check("R11 pal", {22'b0, palFlag}, {22'b0, refPal(8'(v))});
    end
    apply(4'h0, 8'd251, 8'hFF, 1'b0);
    check("R12 251", {22'b0, primeFlag}, 23'd1);
    apply(4'h0, 8'd253, 8'hFF, 1'b0);
    check("R12 253", {22'b0, primeFlag}, 23'd0);

    // R10 and R13 on a subtract with borrow
    apply(4'h9, 8'h00, 8'h01, 1'b0);
    check("R10 any", {7'b0, resHi, 6'b0, anyFlag, ovfFlag}, {7'b0, 8'h00, 6'b0, 2'b10});

    done = 1'b1;
    finish();
  end

endmodule